// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Receiver

This block receives a 64 kbit/s codirectional line signal on two rails, one for positive marks and one for negative marks. From that signal it recovers unit, bit and octet timing and decodes the data bits. Each bit occupies four signalling units. Consecutive bit blocks alternate in polarity. The block that carries the last bit of every octet deliberately repeats the previous polarity, and these violations mark the octet boundaries. The block reports loss of line transitions, which means clock recovery has lost lock, and loss of the expected violations.

Assembled octets pass through a two-register buffer into an 8-clock timeslot on a 2.048 Mbit/s serial output. A select input chooses which of two strobes defines that timeslot. The write side runs on recovered octet timing and the read side runs on local frame timing, so a read from an empty buffer repeats the previous octet. An octet that arrives while both registers are full is dropped. Each of these slips raises a one-clock flag.

All logic runs on one local clock, which also serves as the oversampling clock at `OVS` samples per line unit. The default is 8, which makes one unit 8 clocks, one bit 32 clocks and one octet 256 clocks, so octets arrive at the same rate as 125 µs frames.

Top module: `cd64_rx_decoder`

## Requirements
- R1: A bit block whose units are (nonzero, zero, nonzero, zero) decodes to 0. A block whose units are (nonzero, nonzero, zero, zero) decodes to 1. A block's polarity is that of its first unit. Octets are assembled most significant bit first, and the violating block carries bit 0.
- R2: Octet lock is gained at the third violation when the two gaps between three successive violations are each exactly 8 blocks. Octets are written to the buffer only while locked.
- R3: `alarm_o` is 0 after reset. It rises when three consecutive expected octet positions, each 8 blocks apart, carry no violation, and lock is dropped at the same time. It returns to 0 when lock is regained.
- R4: `los_o` is 1 after reset. It becomes 1 once neither rail has changed for 8*`OVS` clocks, which is two bit periods. It returns to 0 one clock after the first rail change.
- R5: `rec_clk_o` is high during the first two units of every bit block and low during the last two, giving one rising edge per bit.
- R6: When `ts_sel_i` is 0 the timeslot follows `ts_a_i`; when it is 1 the timeslot follows `ts_b_i`. On a rising edge of the selected strobe, the octet is shifted out on `pcm_o` most significant bit first, over the 8 clocks that begin one clock after the edge. `pcm_o` is 0 at all other times.
- R7: When line octets and frames arrive at equal rates, every received octet is output exactly once and in order, and neither slip flag rises.
- R8: A read from an empty buffer outputs the previous octet again and pulses `ins_o` during the first bit of that timeslot.
- R9: An octet that arrives while both registers hold unread data is discarded, and `del_o` pulses for one clock.
- R10: After reset, `pcm_o`, `ins_o`, `del_o`, `alarm_o` and `rec_clk_o` are 0, and `los_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 2.048 MHz local clock, also the oversampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rail_p_i | input | 1 | Positive-mark rail from the line receiver |
| rail_n_i | input | 1 | Negative-mark rail from the line receiver |
| ts_a_i | input | 1 | First timeslot strobe, high for 8 clocks |
| ts_b_i | input | 1 | Second timeslot strobe, high for 8 clocks |
| ts_sel_i | input | 1 | Timeslot select: 0 picks `ts_a_i`, 1 picks `ts_b_i` |
| pcm_o | output | 1 | Serial 2.048 Mbit/s data in the selected timeslot |
| rec_clk_o | output | 1 | Recovered 64 kHz bit clock |
| los_o | output | 1 | Clock-recovery lock lost (no line transitions) |
| alarm_o | output | 1 | Violations lost at expected octet positions |
| ins_o | output | 1 | Octet repeated (buffer empty at read) |
| del_o | output | 1 | Octet dropped (buffer full at write) |

## Verification
The line carries a chain of octets in which each octet is a fixed bijective function of the one before it. That chain covers every bit pattern and lets any repeated or skipped octet be recognised from the previous octet alone.

Frames run at three rates against the fixed octet rate. At equal rates every octet must be the direct successor of the last one. Fast frames must produce repeats and no skips. Slow frames must produce skips and no repeats, which separates insertion from deletion.

Two further patterns test the alarm paths. Suppressing the violations, then restoring them, separates the violation alarm from clock loss. Silencing the rails separates clock loss from the alarm. Both timeslot selections are checked, and the unselected window must stay quiet.

// File: rtl/cd64_rx_pkg.sv
package cd64_rx_pkg;
  localparam int unsigned UNITS_PER_BIT = 4;
  localparam int unsigned OCT_BITS      = 8;
  typedef logic [OCT_BITS-1:0] octet_t;
endpackage

// File: rtl/cd64_unit_timing.sv
module cd64_unit_timing
  import cd64_rx_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_p_i,
  input  logic rail_n_i,
  output logic unit_vld_o,
  output logic unit_p_o,
  output logic unit_n_o,
  output logic los_o
);
  localparam int unsigned CW      = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned LOS_LIM = 2 * UNITS_PER_BIT * OVS;
  localparam int unsigned QW      = $clog2(LOS_LIM + 1);

  logic [1:0]    s1_q, s2_q, s3_q;
  logic [CW-1:0] ph_q;
  logic [QW-1:0] quiet_q;
  logic          los_q;
  logic          change;

  assign change = (s2_q != s3_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= {rail_p_i, rail_n_i};
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // unit phase re-centres on every rail change
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     ph_q <= '0;
    else if (change)                 ph_q <= '0;
    else if (ph_q == CW'(OVS - 1))   ph_q <= '0;
    else                             ph_q <= ph_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= QW'(LOS_LIM);
      los_q   <= 1'b1;
    end else if (change) begin
      quiet_q <= '0;
      los_q   <= 1'b0;
    end else begin
      if (quiet_q != QW'(LOS_LIM)) quiet_q <= quiet_q + 1'b1;
      if (quiet_q == QW'(LOS_LIM - 1)) los_q <= 1'b1;
    end
  end

  assign unit_vld_o = (ph_q == CW'(OVS / 2));
  assign unit_p_o   = s2_q[1];
  assign unit_n_o   = s2_q[0];
  assign los_o      = los_q;

  p_los_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    change |=> !los_o);
endmodule

// File: rtl/cd64_block_dec.sv
module cd64_block_dec
  import cd64_rx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic unit_vld_i,
  input  logic unit_p_i,
  input  logic unit_n_i,
  output logic blk_vld_o,
  output logic bit_o,
  output logic viol_o,
  output logic rec_clk_o
);
  logic       nz, prev_nz_q;
  logic [1:0] uph_q, idx;
  logic       u0_pol_q, u1_nz_q;
  logic       prev_pol_q, pol_vld_q;
  logic       blk_q, bit_q, viol_q, rclk_q;

  assign nz  = unit_p_i | unit_n_i;
  // two adjacent marks can only be units 0 and 1 of a one-block
  assign idx = (prev_nz_q && nz) ? 2'd1 : uph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_nz_q  <= 1'b0;
      uph_q      <= '0;
      u0_pol_q   <= 1'b0;
      u1_nz_q    <= 1'b0;
      prev_pol_q <= 1'b0;
      pol_vld_q  <= 1'b0;
      blk_q      <= 1'b0;
      bit_q      <= 1'b0;
      viol_q     <= 1'b0;
      rclk_q     <= 1'b0;
    end else begin
      blk_q <= 1'b0;
      if (unit_vld_i) begin
        prev_nz_q <= nz;
        uph_q     <= idx + 2'd1;
        rclk_q    <= (idx < 2'd2);
        if (idx == 2'd0) u0_pol_q <= unit_p_i;
        if (idx == 2'd1) u1_nz_q  <= nz;
        if (idx == 2'(UNITS_PER_BIT - 1)) begin
          blk_q      <= 1'b1;
          bit_q      <= u1_nz_q;
          viol_q     <= pol_vld_q && (u0_pol_q == prev_pol_q);
          prev_pol_q <= u0_pol_q;
          pol_vld_q  <= 1'b1;
        end
      end
    end
  end

  assign blk_vld_o = blk_q;
  assign bit_o     = bit_q;
  assign viol_o    = viol_q;
  assign rec_clk_o = rclk_q;

  p_blk_from_unit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_vld_o |-> $past(unit_vld_i));
endmodule

// File: rtl/cd64_octet_framer.sv
module cd64_octet_framer
  import cd64_rx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   blk_vld_i,
  input  logic   bit_i,
  input  logic   viol_i,
  output logic   oct_vld_o,
  output octet_t oct_o,
  output logic   locked_o,
  output logic   alarm_o
);
  localparam logic [3:0] LAST = 4'(OCT_BITS - 1);

  logic [OCT_BITS-2:0] sh_q;
  logic [3:0]          bcnt_q;
  logic [1:0]          good_q, miss_q;
  logic                lock_q, alarm_q, vld_q;
  octet_t              oct_q;
  logic                at_exp;

  assign at_exp = (bcnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      bcnt_q  <= 4'hf;
      good_q  <= '0;
      miss_q  <= '0;
      lock_q  <= 1'b0;
      alarm_q <= 1'b0;
      vld_q   <= 1'b0;
      oct_q   <= '0;
    end else begin
      vld_q <= 1'b0;
      if (blk_vld_i) begin
        sh_q  <= {sh_q[OCT_BITS-3:0], bit_i};
        oct_q <= {sh_q, bit_i};
        if (!lock_q) begin
          if (viol_i) begin
            bcnt_q <= '0;
            if (at_exp && good_q == 2'd1) begin
              lock_q  <= 1'b1;
              alarm_q <= 1'b0;
              miss_q  <= '0;
              good_q  <= '0;
              vld_q   <= 1'b1;
            end else begin
              good_q <= at_exp ? 2'd1 : 2'd0;
            end
          end else if (bcnt_q != 4'hf) begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end else if (at_exp) begin
          bcnt_q <= '0;
          if (viol_i) begin
            miss_q <= '0;
            vld_q  <= 1'b1;
          end else if (miss_q == 2'd2) begin
            lock_q  <= 1'b0;
            alarm_q <= 1'b1;
            miss_q  <= '0;
            good_q  <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
            vld_q  <= 1'b1;
          end
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign oct_vld_o = vld_q;
  assign oct_o     = oct_q;
  assign locked_o  = lock_q;
  assign alarm_o   = alarm_q;

  p_alarm_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_o |-> !locked_o);
  p_emit_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_vld_o |-> locked_o);
endmodule

// File: rtl/cd64_slip_buf.sv
module cd64_slip_buf
  import cd64_rx_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   wr_i,
  input  octet_t wr_data_i,
  input  logic   rd_i,
  output octet_t rd_data_o,
  output logic   ins_o,
  output logic   del_o
);
  octet_t     mem_q [2];
  octet_t     last_q;
  logic       wr_ptr_q, rd_ptr_q;
  logic [1:0] fill_q, fill_mid;
  logic       rd_take, wr_ok;
  logic       ins_q, del_q;

  // a read frees its register before a same-cycle write is judged
  assign rd_take   = rd_i && (fill_q != 2'd0);
  assign fill_mid  = fill_q - {1'b0, rd_take};
  assign wr_ok     = wr_i && (fill_mid != 2'd2);
  assign rd_data_o = rd_take ? mem_q[rd_ptr_q] : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q[0] <= '0;
      mem_q[1] <= '0;
      last_q   <= '0;
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
      fill_q   <= '0;
      ins_q    <= 1'b0;
      del_q    <= 1'b0;
    end else begin
      ins_q  <= rd_i && !rd_take;
      del_q  <= wr_i && !wr_ok;
      fill_q <= fill_mid + {1'b0, wr_ok};
      if (rd_i)    last_q   <= rd_data_o;
      if (rd_take) rd_ptr_q <= ~rd_ptr_q;
      if (wr_ok) begin
        mem_q[wr_ptr_q] <= wr_data_i;
        wr_ptr_q        <= ~wr_ptr_q;
      end
    end
  end

  assign ins_o = ins_q;
  assign del_o = del_q;

  p_fill_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= 2'd2);
  p_slip_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ins_o && del_o));
  p_ins_repeat_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> $stable(last_q));
endmodule

// File: rtl/cd64_rx_decoder.sv
module cd64_rx_decoder
  import cd64_rx_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rail_p_i,
  input  logic rail_n_i,
  input  logic ts_a_i,
  input  logic ts_b_i,
  input  logic ts_sel_i,
  output logic pcm_o,
  output logic rec_clk_o,
  output logic los_o,
  output logic alarm_o,
  output logic ins_o,
  output logic del_o
);
  localparam int unsigned AW = $clog2(OCT_BITS + 1);

  logic   unit_vld, unit_p, unit_n;
  logic   blk_vld, blk_bit, blk_viol;
  logic   oct_vld, locked;
  octet_t oct, rd_data, sh_q;
  logic   ts, ts_q, rd_start;
  logic [AW-1:0] act_q;

  cd64_unit_timing #(.OVS(OVS)) u_timing (
    .clk_i, .rst_ni, .rail_p_i, .rail_n_i,
    .unit_vld_o(unit_vld), .unit_p_o(unit_p), .unit_n_o(unit_n), .los_o(los_o)
  );

  cd64_block_dec u_dec (
    .clk_i, .rst_ni, .unit_vld_i(unit_vld), .unit_p_i(unit_p), .unit_n_i(unit_n),
    .blk_vld_o(blk_vld), .bit_o(blk_bit), .viol_o(blk_viol), .rec_clk_o(rec_clk_o)
  );

  cd64_octet_framer u_frm (
    .clk_i, .rst_ni, .blk_vld_i(blk_vld), .bit_i(blk_bit), .viol_i(blk_viol),
    .oct_vld_o(oct_vld), .oct_o(oct), .locked_o(locked), .alarm_o(alarm_o)
  );

  assign ts       = ts_sel_i ? ts_b_i : ts_a_i;
  assign rd_start = ts && !ts_q;

  cd64_slip_buf u_buf (
    .clk_i, .rst_ni, .wr_i(oct_vld), .wr_data_i(oct), .rd_i(rd_start),
    .rd_data_o(rd_data), .ins_o(ins_o), .del_o(del_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= 1'b0;
      sh_q  <= '0;
      act_q <= '0;
    end else begin
      ts_q <= ts;
      if (rd_start) begin
        sh_q  <= rd_data;
        act_q <= AW'(OCT_BITS);
      end else if (act_q != '0) begin
        sh_q  <= {sh_q[OCT_BITS-2:0], 1'b0};
        act_q <= act_q - 1'b1;
      end
    end
  end

  assign pcm_o = (act_q != '0) && sh_q[OCT_BITS-1];

  p_lock_needs_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oct_vld |-> locked);
endmodule

// File: tb/sim_cd64_rx_decoder.sv
`timescale 1ns/1ps
module sim_cd64_rx_decoder;
  localparam int OVS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail_p = 1'b0, rail_n = 1'b0;
  logic ts_a, ts_b;
  logic ts_sel = 1'b0;
  logic pcm, rec_clk, los, alarm, ins, del;

  always #2.5 clk = ~clk;

  cd64_rx_decoder #(.OVS(OVS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rail_p_i(rail_p), .rail_n_i(rail_n),
    .ts_a_i(ts_a), .ts_b_i(ts_b), .ts_sel_i(ts_sel),
    .pcm_o(pcm), .rec_clk_o(rec_clk), .los_o(los), .alarm_o(alarm),
    .ins_o(ins), .del_o(del)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] x);
    return 8'(x * 8'd5 + 8'd1);
  endfunction

  // line generator: 4 units per bit, violation on bit 0 of each octet
  bit line_en = 0, viol_en = 1;
  int uc = 0, un = 0, bk = 0;
  logic [7:0] cur = 8'h3c;
  logic pol = 1'b1;
  always @(negedge clk) begin
    logic b, nzu;
    b = cur[7-bk];
    case (un)
      0: nzu = 1'b1;
      1: nzu = b;
      2: nzu = !b;
      default: nzu = 1'b0;
    endcase
    rail_p = line_en && nzu && pol;
    rail_n = line_en && nzu && !pol;
    uc++;
    if (uc == OVS) begin
      uc = 0;
      un++;
      if (un == 4) begin
        un = 0;
        if (!((bk + 1) % 8 == 7 && viol_en)) pol = ~pol;
        bk++;
        if (bk == 8) begin
          bk = 0;
          cur = nxt(cur);
        end
      end
    end
  end

  // frame strobes and capture
  int fc = 0, fp = 256;
  int mode = 0, phase_id = 0, seen_phase = -1;
  assign ts_a = (fc < 8);
  assign ts_b = (fc >= 64) && (fc < 72);
  logic [7:0] cap, last;
  bit have_last = 0, cap_ins = 0, qbad = 0;
  always @(negedge clk) begin
    int sb, ob;
    if (phase_id != seen_phase) begin
      have_last = 0;
      seen_phase = phase_id;
    end
    sb = ts_sel ? 64 : 0;
    ob = ts_sel ? 0 : 64;
    if (fc >= sb && fc < sb + 8) begin
      cap[7-(fc-sb)] = pcm;
      if (fc == sb) cap_ins = ins;
      if (fc == sb + 7) begin
        if (mode != 0 && have_last) begin
          case (mode)
            1: chk(cap == nxt(last) && !cap_ins, "R7 R1 in-order octet", int'(cap), int'(nxt(last)));
            2: chk(cap_ins ? cap == last : cap == nxt(last), "R8 repeat only on insertion", int'(cap), int'(cap_ins ? last : nxt(last)));
            default: chk(cap == nxt(last) || cap == nxt(nxt(last)), "R9 at most one octet skipped", int'(cap), int'(nxt(last)));
          endcase
        end
        last = cap;
        have_last = 1;
      end
    end
    if (fc >= ob && fc < ob + 8 && pcm) qbad = 1;
    if (fc == ob + 7) begin
      if (mode != 0) chk(!qbad, "R6 unselected timeslot quiet", int'(qbad), 0);
      qbad = 0;
    end
    fc = (fc >= fp - 1) ? 0 : fc + 1;
  end

  int ins_cnt = 0, del_cnt = 0, rise_cnt = 0;
  logic rclk_d = 1'b0;
  always @(negedge clk) begin
    if (ins) ins_cnt++;
    if (del) del_cnt++;
    if (rec_clk && !rclk_d) rise_cnt++;
    rclk_d = rec_clk;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_phase(input int m, input int frames, input int period, output int di, output int dd);
    int i0, d0;
    mode = 0;
    fp = period;
    wait_clk(3 * period);
    phase_id++;
    i0 = ins_cnt;
    d0 = del_cnt;
    mode = m;
    wait_clk(frames * period);
    mode = 0;
    di = ins_cnt - i0;
    dd = del_cnt - d0;
  endtask

  initial begin
    int di, dd, r0;
    wait_clk(5);
    chk(los == 1'b1, "R10 R4 los after reset", int'(los), 1);
    chk(alarm == 1'b0, "R10 R3 alarm after reset", int'(alarm), 0);
    chk(pcm == 1'b0 && ins == 1'b0 && del == 1'b0, "R10 outputs idle", int'({pcm, ins, del}), 0);
    chk(rec_clk == 1'b0, "R10 rec clock low", int'(rec_clk), 0);
    rst_n = 1'b1;
    line_en = 1;
    wait_clk(6 * 256);
    chk(los == 1'b0, "R4 lock with live line", int'(los), 0);
    chk(alarm == 1'b0, "R3 no alarm with violations", int'(alarm), 0);

    r0 = rise_cnt;
    wait_clk(2560);
    chk((rise_cnt - r0) >= 79 && (rise_cnt - r0) <= 81, "R5 one recovered clock per bit", rise_cnt - r0, 80);

    run_phase(1, 20, 256, di, dd);
    chk(di == 0 && dd == 0, "R7 no slips timeslot A", di + dd, 0);

    while (fc != 128) @(negedge clk);
    ts_sel = 1'b1;
    run_phase(1, 20, 256, di, dd);
    chk(di == 0 && dd == 0, "R7 R6 no slips timeslot B", di + dd, 0);

    run_phase(2, 80, 248, di, dd);
    chk(di > 0, "R8 fast frames insert", di, 1);
    chk(dd == 0, "R8 fast frames never delete", dd, 0);

    run_phase(3, 80, 264, di, dd);
    chk(dd > 0, "R9 slow frames delete", dd, 1);
    chk(di == 0, "R9 slow frames never insert", di, 0);

    fp = 256;
    wait_clk(512);
    viol_en = 0;
    wait_clk(400);
    chk(alarm == 1'b0, "R3 no alarm before third miss", int'(alarm), 0);
    wait_clk(700);
    chk(alarm == 1'b1, "R3 alarm after three misses", int'(alarm), 1);
    chk(los == 1'b0, "R4 clock still locked without violations", int'(los), 0);
    viol_en = 1;
    wait_clk(1400);
    chk(alarm == 1'b0, "R3 R2 alarm cleared on relock", int'(alarm), 0);
    run_phase(1, 10, 256, di, dd);
    chk(di == 0 && dd == 0, "R2 clean stream after relock", di + dd, 0);

    line_en = 0;
    wait_clk(30);
    chk(los == 1'b0, "R4 los held before two bits", int'(los), 0);
    wait_clk(40);
    chk(los == 1'b1, "R4 los after two silent bits", int'(los), 1);
    line_en = 1;
    wait_clk(20);
    chk(los == 1'b0, "R4 los clears on transition", int'(los), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule